// File: doc/BRIEF.md
# Multi-Cycle Multiply Unit with Issue Occupancy

This block is a single shared multiplier that sits beside an execution pipeline. An issuer presents one request per cycle: an operation code, two 32-bit operands and a small tag. The unit offers three operations. The first is a signed multiply of the low halfwords. The second is a 32x32 multiply that keeps the low word. The third is a 32x32 unsigned multiply with a 64-bit result. Each operation holds the issue port for a fixed number of cycles. Each operation returns its result a fixed number of cycles later. The tag comes back with every result so that the issuer can route it.

Results leave on two result ports. The low port carries every 32-bit result and the low word of a 64-bit product. The high port carries only the upper word of a 64-bit product, which arrives one cycle after its low word. An issue slot is reserved on the low port when the request is accepted. A request whose low result would land on a cycle that is already claimed is refused until the slot is clear.

Timing convention: a request is accepted in cycle T when `iss_valid` and `iss_ready` are both high at the rising edge that closes cycle T. "Cycle T+n" means the n-th cycle after that one.

Top module: `mulocc_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `iss_ready` is high for operation code 0, and `lo_valid` and `hi_valid` are low.
- R2: Code 0 (halfword multiply) forms the signed product of bits 15:0 of each operand as a 32-bit two's-complement value. It appears on `lo_data` with `lo_valid` high in cycle T+3. It holds the port for one cycle only.
- R3: Code 1 (word multiply) returns bits 31:0 of the product on `lo_data` in cycle T+4. `iss_ready` is low in cycle T+1.
- R4: Code 2 (long multiply) forms the unsigned 64-bit product. Bits 31:0 appear on the low port in cycle T+6, and bits 63:32 appear on the high port in cycle T+7. `iss_ready` is low in cycles T+1 and T+2.
- R5: Code 3 is reserved. `iss_ready` is low whenever code 3 is presented, and such a request never produces a result.
- R6: A request presented while `iss_ready` is low is not taken. It produces no result and no occupancy.
- R7: Each accepted operation raises each of its result valids for exactly one cycle. The tag given at issue accompanies each result. Apart from these cycles, neither valid is ever high.
- R8: A halfword multiply presented in cycle T+3 after a long multiply is refused, because its result would collide with the long multiply's low word. The same request held one more cycle is accepted in T+4.
- R9: Halfword multiplies can be accepted on consecutive cycles. Their results then appear on consecutive cycles in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid | input | 1 | Issue request present |
| iss_op | input | 2 | Operation code: 0 halfword, 1 word, 2 long, 3 reserved |
| iss_tag | input | TAG_W | Tag returned with the results |
| iss_a | input | 32 | First operand |
| iss_b | input | 32 | Second operand |
| iss_ready | output | 1 | Unit can take the presented request this cycle |
| lo_valid | output | 1 | Low result port valid (one-cycle pulse) |
| lo_tag | output | TAG_W | Tag of the low result |
| lo_data | output | 32 | Low result word |
| hi_valid | output | 1 | High result port valid (one-cycle pulse) |
| hi_tag | output | TAG_W | Tag of the high result |
| hi_data | output | 32 | Upper word of a long product |

## Verification
Two pairs of results can compete for the same cycle. A halfword multiply issued three cycles after a long multiply would land on the low port together with the long multiply's low word. A word multiply issued three cycles after a long multiply finishes together with the long multiply's high word, but on the other port. The bench provokes both cases with a sweep over every ordered pair of operations and every gap from zero to seven idle cycles. It predicts `iss_ready` in every cycle from its own slot schedule. It then checks that each result arrives on its own cycle and port, with the correct value and tag, and that nothing appears anywhere else.

// File: rtl/mulocc_pkg.sv
`timescale 1ns/1ps
// Package: shared operation codes and timing constants of the multiply unit.
// Assumes operands are one machine word wide; all timing derives from the
// occupancy and latency figures below.
package mulocc_pkg;

    localparam int XLEN = 32;

    typedef enum logic [1:0] {
        OP_H16 = 2'd0,
        OP_W32 = 2'd1,
        OP_D64 = 2'd2,
        OP_RSV = 2'd3
    } mul_op_e;

    // Cycles each operation holds the issue port.
    localparam int OCC_H16 = 1;
    localparam int OCC_W32 = 2;
    localparam int OCC_D64 = 3;

    // Cycles from the end of occupancy to the result.
    localparam int LAT_H16    = 3;
    localparam int LAT_W32    = 3;
    localparam int LAT_D64_LO = 4;
    localparam int LAT_D64_HI = 5;

    // Result cycle counted from the acceptance cycle.
    localparam int DUE_H16    = OCC_H16 - 1 + LAT_H16;
    localparam int DUE_W32    = OCC_W32 - 1 + LAT_W32;
    localparam int DUE_D64_LO = OCC_D64 - 1 + LAT_D64_LO;
    localparam int DUE_D64_HI = OCC_D64 - 1 + LAT_D64_HI;

    localparam int QDEPTH     = DUE_D64_HI + 1;
    localparam int SLOT_IDX_W = $clog2(QDEPTH);
    localparam int OCC_CNT_W  = $clog2(OCC_D64);

endpackage

// File: rtl/mulocc_product.sv
`timescale 1ns/1ps
// Module: mulocc_product
// Combinational product former. Produces the low and high result words for
// the selected operation. Assumes the operands are stable in the issue cycle.
module mulocc_product
    import mulocc_pkg::*;
(
    input  mul_op_e          op,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    output logic [XLEN-1:0]  res_lo,
    output logic [XLEN-1:0]  res_hi
);

    localparam int HW = XLEN / 2;

    logic signed [XLEN-1:0]   half_prod;
    logic        [2*XLEN-1:0] wide_prod;

    // Form both raw products.
    always_comb begin
        half_prod = $signed(opa[HW-1:0]) * $signed(opb[HW-1:0]);
        wide_prod = {{XLEN{1'b0}}, opa} * {{XLEN{1'b0}}, opb};
    end

    // Select the result words for the operation.
    always_comb begin
        res_lo = '0;
        res_hi = '0;
        case (op)
            OP_H16: res_lo = half_prod;
            OP_W32: res_lo = wide_prod[XLEN-1:0];
            OP_D64: begin
                res_lo = wide_prod[XLEN-1:0];
                res_hi = wide_prod[2*XLEN-1:XLEN];
            end
            default: begin
                res_lo = '0;
                res_hi = '0;
            end
        endcase
    end

endmodule

// File: rtl/mulocc_slot_queue.sv
`timescale 1ns/1ps
// Module: mulocc_slot_queue
// Timed result queue. Entry k holds a result due k cycles after the current
// one, so the queue shifts toward entry 0 every cycle and entry 0 is the port.
// An insert writes entry ins_idx. The caller guarantees that this slot is empty.
module mulocc_slot_queue #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 36
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ins_en,
    input  logic [$clog2(DEPTH)-1:0] ins_idx,
    input  logic [WIDTH-1:0]         ins_data,
    output logic                     head_valid,
    output logic [WIDTH-1:0]         head_data,
    output logic [DEPTH-1:0]         busy
);

    localparam int IDX_W = $clog2(DEPTH);

    logic [WIDTH-1:0] slot_data [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        logic             v_q;
        logic [WIDTH-1:0] d_q;
        logic             v_nxt;
        logic [WIDTH-1:0] d_nxt;

        if (k == DEPTH - 1) begin : g_tail
            assign v_nxt = 1'b0;
            assign d_nxt = '0;
        end else begin : g_body
            assign v_nxt = busy[k+1];
            assign d_nxt = slot_data[k+1];
        end

        // Advance the slot by one cycle or load a new result.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= '0;
            end else if (ins_en && ins_idx == IDX_W'(k)) begin
                v_q <= 1'b1;
                d_q <= ins_data;
            end else begin
                v_q <= v_nxt;
                d_q <= d_nxt;
            end
        end

        assign busy[k]      = v_q;
        assign slot_data[k] = d_q;
    end

    assign head_valid = busy[0];
    assign head_data  = slot_data[0];

endmodule

// File: rtl/mulocc_issue.sv
`timescale 1ns/1ps
// Module: mulocc_issue
// Issue control. It tracks the remaining occupancy of the last accepted
// operation and refuses a request while the port is held or while the
// request's result slot is already claimed. Reserved codes are never accepted.
module mulocc_issue
    import mulocc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  mul_op_e               req_op,
    input  logic [QDEPTH-1:0]     lo_busy,
    input  logic [QDEPTH-1:0]     hi_busy,
    output logic                  req_ready,
    output logic                  req_accept,
    output logic [SLOT_IDX_W-1:0] lo_idx
);

    logic [OCC_CNT_W-1:0]  occ_left;
    logic [OCC_CNT_W-1:0]  occ_need;
    logic [SLOT_IDX_W-1:0] lo_due;
    logic [QDEPTH-1:0]     lo_mask;
    logic [QDEPTH-1:0]     hi_mask;
    logic                  op_legal;
    logic                  slot_clash;

    // Decode the occupancy and the low-port result slot of the request.
    always_comb begin
        op_legal = 1'b1;
        occ_need = '0;
        lo_due   = '0;
        case (req_op)
            OP_H16: begin
                occ_need = OCC_CNT_W'(OCC_H16 - 1);
                lo_due   = SLOT_IDX_W'(DUE_H16);
            end
            OP_W32: begin
                occ_need = OCC_CNT_W'(OCC_W32 - 1);
                lo_due   = SLOT_IDX_W'(DUE_W32);
            end
            OP_D64: begin
                occ_need = OCC_CNT_W'(OCC_D64 - 1);
                lo_due   = SLOT_IDX_W'(DUE_D64_LO);
            end
            default: op_legal = 1'b0;
        endcase
    end

    // Detect a result slot already claimed on either port.
    always_comb begin
        lo_mask    = QDEPTH'(1) << lo_due;
        hi_mask    = (req_op == OP_D64) ? (QDEPTH'(1) << DUE_D64_HI) : '0;
        slot_clash = |(lo_busy & lo_mask) | |(hi_busy & hi_mask);
    end

    assign req_ready  = (occ_left == '0) && op_legal && !slot_clash;
    assign req_accept = req_valid && req_ready;
    assign lo_idx     = lo_due - SLOT_IDX_W'(1);

    // Count down the cycles the port remains held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_left <= '0;
        end else if (req_accept) begin
            occ_left <= occ_need;
        end else if (occ_left != '0) begin
            occ_left <= occ_left - OCC_CNT_W'(1);
        end
    end

endmodule

// File: rtl/mulocc_unit.sv
`timescale 1ns/1ps
// Module: mulocc_unit (top)
// Shared multiply unit with per-operation port occupancy and fixed result
// timing. Results leave on a low port and a high port, each with its tag.
// Assumes that the issuer holds a refused request or withdraws it freely.
module mulocc_unit
    import mulocc_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [1:0]       iss_op,
    input  logic [TAG_W-1:0] iss_tag,
    input  logic [XLEN-1:0]  iss_a,
    input  logic [XLEN-1:0]  iss_b,
    output logic             iss_ready,
    output logic             lo_valid,
    output logic [TAG_W-1:0] lo_tag,
    output logic [XLEN-1:0]  lo_data,
    output logic             hi_valid,
    output logic [TAG_W-1:0] hi_tag,
    output logic [XLEN-1:0]  hi_data
);

    localparam int ENT_W = TAG_W + XLEN;

    mul_op_e               op_e;
    logic                  accept_w;
    logic [SLOT_IDX_W-1:0] lo_idx;
    logic [QDEPTH-1:0]     lo_busy;
    logic [QDEPTH-1:0]     hi_busy;
    logic [XLEN-1:0]       prod_lo;
    logic [XLEN-1:0]       prod_hi;
    logic [ENT_W-1:0]      lo_head;
    logic [ENT_W-1:0]      hi_head;

    assign op_e = mul_op_e'(iss_op);

    mulocc_issue u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (iss_valid),
        .req_op     (op_e),
        .lo_busy    (lo_busy),
        .hi_busy    (hi_busy),
        .req_ready  (iss_ready),
        .req_accept (accept_w),
        .lo_idx     (lo_idx)
    );

    mulocc_product u_prod (
        .op     (op_e),
        .opa    (iss_a),
        .opb    (iss_b),
        .res_lo (prod_lo),
        .res_hi (prod_hi)
    );

    mulocc_slot_queue #(.DEPTH(QDEPTH), .WIDTH(ENT_W)) u_lo_q (
        .clk        (clk),
        .rst_n      (rst_n),
        .ins_en     (accept_w),
        .ins_idx    (lo_idx),
        .ins_data   ({iss_tag, prod_lo}),
        .head_valid (lo_valid),
        .head_data  (lo_head),
        .busy       (lo_busy)
    );

    mulocc_slot_queue #(.DEPTH(QDEPTH), .WIDTH(ENT_W)) u_hi_q (
        .clk        (clk),
        .rst_n      (rst_n),
        .ins_en     (accept_w && op_e == OP_D64),
        .ins_idx    (SLOT_IDX_W'(DUE_D64_HI - 1)),
        .ins_data   ({iss_tag, prod_hi}),
        .head_valid (hi_valid),
        .head_data  (hi_head),
        .busy       (hi_busy)
    );

    assign lo_tag  = lo_head[ENT_W-1:XLEN];
    assign lo_data = lo_head[XLEN-1:0];
    assign hi_tag  = hi_head[ENT_W-1:XLEN];
    assign hi_data = hi_head[XLEN-1:0];

endmodule

// File: rtl/mulocc_checker.sv
`timescale 1ns/1ps
// Module: mulocc_checker
// Timing properties of the multiply unit, attached to the top by bind.
// Assumes the fixed timing of the package (due cycles 3, 4, 6 and 7).
module mulocc_checker #(
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_ready,
    input logic             iss_accept,
    input logic [1:0]       iss_op,
    input logic [TAG_W-1:0] iss_tag,
    input logic             lo_valid,
    input logic [TAG_W-1:0] lo_tag,
    input logic             hi_valid,
    input logic [TAG_W-1:0] hi_tag
);

    logic [3:0] age;
    logic acc_h16, acc_w32, acc_d64;

    assign acc_h16 = iss_accept && iss_op == 2'd0;
    assign acc_w32 = iss_accept && iss_op == 2'd1;
    assign acc_d64 = iss_accept && iss_op == 2'd2;

    // Count cycles since reset so that history looks only at valid samples.
    always_ff @(posedge clk) begin
        if (!rst_n)            age <= '0;
        else if (age != 4'hF)  age <= age + 4'd1;
    end

    p_h16_due_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 4'd4 && $past(acc_h16, 3)) |-> (lo_valid && lo_tag == $past(iss_tag, 3)));

    p_w32_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 4'd5 && $past(acc_w32, 4)) |-> (lo_valid && lo_tag == $past(iss_tag, 4)));

    p_w32_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_w32 |=> !iss_ready);

    p_d64_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 4'd7 && $past(acc_d64, 6)) |-> (lo_valid && lo_tag == $past(iss_tag, 6)));

    p_d64_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 4'd8 && $past(acc_d64, 7)) |-> (hi_valid && hi_tag == $past(iss_tag, 7)));

    p_d64_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 4'd3 && $past(acc_d64, 2)) |-> !iss_ready);

    p_hi_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 4'd8 && hi_valid) |-> $past(acc_d64, 7));

    p_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_op == 2'd3) |-> !iss_ready);

    p_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 4'd4 && $past(acc_d64, 3) && iss_op == 2'd0) |-> !iss_ready);

endmodule

bind mulocc_unit mulocc_checker #(.TAG_W(TAG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_ready  (iss_ready),
    .iss_accept (accept_w),
    .iss_op     (iss_op),
    .iss_tag    (iss_tag),
    .lo_valid   (lo_valid),
    .lo_tag     (lo_tag),
    .hi_valid   (hi_valid),
    .hi_tag     (hi_tag)
);

// File: tb/mulocc_unit_test.sv
`timescale 1ns/1ps
// Bench: sweeps corner operands over every operation, every ordered pair of
// operations at gaps 0..7, and a pseudo-random stream. Readiness and every
// result cycle are predicted from an independent slot schedule.
module mulocc_unit_test;

    localparam int TAG_W = 4;
    localparam int NSLOT = 8192;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             iss_valid;
    logic [1:0]       iss_op;
    logic [TAG_W-1:0] iss_tag;
    logic [31:0]      iss_a, iss_b;
    logic             iss_ready;
    logic             lo_valid, hi_valid;
    logic [TAG_W-1:0] lo_tag, hi_tag;
    logic [31:0]      lo_data, hi_data;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int free_at = 0;
    int last_acc = 0;
    logic [TAG_W-1:0] tag_ctr = '0;

    logic             exp_lo_v [NSLOT];
    logic [31:0]      exp_lo_d [NSLOT];
    logic [TAG_W-1:0] exp_lo_t [NSLOT];
    logic             exp_hi_v [NSLOT];
    logic [31:0]      exp_hi_d [NSLOT];
    logic [TAG_W-1:0] exp_hi_t [NSLOT];

    localparam logic [31:0] CV [10] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h0000_7FFF,
        32'h0000_8000, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1234_5678, 32'hDEAD_BEEF, 32'hFFFF_0003};

    mulocc_unit #(.TAG_W(TAG_W)) uut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_tag(iss_tag), .iss_a(iss_a), .iss_b(iss_b), .iss_ready(iss_ready),
        .lo_valid(lo_valid), .lo_tag(lo_tag), .lo_data(lo_data),
        .hi_valid(hi_valid), .hi_tag(hi_tag), .hi_data(hi_data)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int due_of(input logic [1:0] op);
        return (op == 2'd0) ? 3 : (op == 2'd1) ? 4 : 6;
    endfunction

    function automatic int occ_of(input logic [1:0] op);
        return (op == 2'd0) ? 1 : (op == 2'd1) ? 2 : 3;
    endfunction

    function automatic logic [31:0] ref_lo(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        int sa, sb;
        longint unsigned w;
        sa = a[15] ? int'(a[15:0]) - 65536 : int'(a[15:0]);
        sb = b[15] ? int'(b[15:0]) - 65536 : int'(b[15:0]);
        w  = 64'(a) * 64'(b);
        if (op == 2'd0) return 32'(sa * sb);
        return w[31:0];
    endfunction

    function automatic logic [31:0] ref_hi(input logic [31:0] a, input logic [31:0] b);
        longint unsigned w;
        w = 64'(a) * 64'(b);
        return w[63:32];
    endfunction

    task automatic check(input bit ok, input string what, input longint act, input longint expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", what, act, expv, cyc);
        end
    endtask

    // One cycle: drive at the falling edge, judge readiness, record the schedule.
    task automatic step(input bit v, input logic [1:0] op, input logic [31:0] a,
                        input logic [31:0] b, output bit took);
        bit rdy_exp;
        iss_valid = v; iss_op = op; iss_a = a; iss_b = b; iss_tag = tag_ctr;
        #5;
        rdy_exp = (cyc >= free_at) && (op != 2'd3) && !exp_lo_v[cyc + due_of(op)];
        check(iss_ready == rdy_exp, "ready R2/R3/R4/R5/R8", longint'(iss_ready), longint'(rdy_exp));
        took = v && iss_ready;
        if (took) begin
            last_acc = cyc;
            free_at  = cyc + occ_of(op);
            exp_lo_v[cyc + due_of(op)] = 1'b1;
            exp_lo_d[cyc + due_of(op)] = ref_lo(op, a, b);
            exp_lo_t[cyc + due_of(op)] = tag_ctr;
            if (op == 2'd2) begin
                exp_hi_v[cyc + 7] = 1'b1;
                exp_hi_d[cyc + 7] = ref_hi(a, b);
                exp_hi_t[cyc + 7] = tag_ctr;
            end
            tag_ctr = tag_ctr + 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        bit t = 1'b0;
        while (!t) step(1'b1, op, a, b, t);
    endtask

    task automatic idle(input int n);
        bit t;
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, 32'h0, 32'h0, t);
    endtask

    // Compare both result ports against the schedule every cycle (R2, R3, R4, R6, R7).
    always @(negedge clk) begin
        if (rst_n === 1'b1 && cyc < NSLOT) begin
            if (exp_lo_v[cyc] || lo_valid) begin
                check(lo_valid == exp_lo_v[cyc], "lo_valid R6/R7", longint'(lo_valid), longint'(exp_lo_v[cyc]));
                if (exp_lo_v[cyc]) begin
                    check(lo_data == exp_lo_d[cyc], "lo_data R2/R3/R4", longint'(lo_data), longint'(exp_lo_d[cyc]));
                    check(lo_tag == exp_lo_t[cyc], "lo_tag R7", longint'(lo_tag), longint'(exp_lo_t[cyc]));
                end
            end
            if (exp_hi_v[cyc] || hi_valid) begin
                check(hi_valid == exp_hi_v[cyc], "hi_valid R4/R7", longint'(hi_valid), longint'(exp_hi_v[cyc]));
                if (exp_hi_v[cyc]) begin
                    check(hi_data == exp_hi_d[cyc], "hi_data R4", longint'(hi_data), longint'(exp_hi_d[cyc]));
                    check(hi_tag == exp_hi_t[cyc], "hi_tag R7", longint'(hi_tag), longint'(exp_hi_t[cyc]));
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int t0;
        bit t;
        logic [31:0] lf = 32'h1ACE_B00C;
        for (int i = 0; i < NSLOT; i++) begin
            exp_lo_v[i] = 1'b0; exp_lo_d[i] = '0; exp_lo_t[i] = '0;
            exp_hi_v[i] = 1'b0; exp_hi_d[i] = '0; exp_hi_t[i] = '0;
        end
        rst_n = 1'b0; iss_valid = 1'b0; iss_op = 2'd0; iss_tag = '0; iss_a = '0; iss_b = '0;
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(iss_ready == 1'b1, "R1 ready in reset", longint'(iss_ready), 1);
        check(lo_valid == 1'b0 && hi_valid == 1'b0, "R1 valids in reset", longint'({lo_valid, hi_valid}), 0);
        rst_n = 1'b1;
        free_at = cyc;
        idle(1);
        check(lo_valid == 1'b0 && hi_valid == 1'b0, "R1 valids after reset", longint'({lo_valid, hi_valid}), 0);

        // R9: halfword multiplies on consecutive cycles.
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 2'd0, CV[i], CV[9-i], t);
            check(t == 1'b1, "R9 back-to-back accept", longint'(t), 1);
        end
        idle(8);

        // R3: word multiply holds the port for two cycles.
        issue(2'd1, 32'h0001_0003, 32'hFFFF_FFFB); t0 = last_acc;
        issue(2'd0, 32'h5, 32'h7);
        check(last_acc - t0 == 2, "R3 next accept gap", longint'(last_acc - t0), 2);
        idle(8);

        // R4: long multiply holds the port for three cycles.
        issue(2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF); t0 = last_acc;
        issue(2'd1, 32'h3, 32'h9);
        check(last_acc - t0 == 3, "R4 next accept gap", longint'(last_acc - t0), 3);
        idle(9);

        // R8: halfword after long multiply is pushed back one cycle.
        issue(2'd2, 32'h8000_0001, 32'h0000_0002); t0 = last_acc;
        issue(2'd0, 32'h0000_8000, 32'h0000_8000);
        check(last_acc - t0 == 4, "R8 collision deferral", longint'(last_acc - t0), 4);
        idle(9);

        // R5: reserved code is never accepted.
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 2'd3, 32'h11, 32'h22, t);
            check(t == 1'b0, "R5 reserved refused", longint'(t), 0);
        end
        idle(8);

        // Corner operand sweep over all operations (R2, R3, R4).
        for (int op = 0; op < 3; op++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    issue(2'(op), CV[i], CV[j]);
        idle(9);

        // Every ordered pair of operations at every gap (R6, R8).
        for (int o1 = 0; o1 < 3; o1++)
            for (int o2 = 0; o2 < 3; o2++)
                for (int g = 0; g < 8; g++) begin
                    issue(2'(o1), CV[g], CV[9-g]);
                    idle(g);
                    issue(2'(o2), CV[9-g], CV[(g+3)%10]);
                    idle(8);
                end

        // Pseudo-random stream including refused and reserved requests.
        for (int i = 0; i < 1500; i++) begin
            lf = lf * 32'd1664525 + 32'd1013904223;
            step(lf[31], lf[29:28], lf ^ 32'h9E37_79B9, {lf[15:0], lf[31:16]}, t);
        end
        idle(10);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule